// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds, for use by precision time protocol logic. Each cycle of the reference clock it adds a 32-bit frequency-compensation addend into a 32-bit phase accumulator. On every cycle where that addition overflows, the time value steps forward by a programmed whole number of nanoseconds. Software can therefore trim the rate in parts-per-billion steps, and each visible step is still an exact integer period. The right addend is the ceiling of 2^32 divided by the ratio of reference frequency to nominal frequency, and that ratio must be greater than one. For example, a 10 ns nominal period taken from a faster reference uses 0x999999A4.

Software reaches the block through a small word-wide register port with four locations: control, addend, low count word and high count word. The 64-bit count is read low word first. That read freezes the matching high word, so the two halves always belong together. It is written low word first. The low half waits in a staging register until the high half arrives, and then both load at once. The current count is also driven on a parallel output for neighbouring timestamp logic.

Top module: `ns_time_counter`

## Requirements
- R1: While enabled and not bypassed, every reference cycle adds the addend into the 32-bit accumulator modulo 2^32, and the count advances by the period exactly on cycles where that addition carries out. Otherwise it holds. The `timeNow` output always shows the count.
- R2: Register map (regAddr): 0 = control, 1 = addend, 2 = count low word, 3 = count high word. Control fields: period in bits 25:16, clock-source select in bits 1:0, enable in bit 2, bypass in bit 3, soft reset in bit 5. A control read returns the stored fields and 0 in every other bit, bit 5 included.
- R3: With bypass set and the timer enabled, the count advances by the period on every reference cycle, and the accumulator keeps its value.
- R4: With enable clear, neither the accumulator nor the count changes, and register writes still take effect.
- R5: A control write with bit 5 set clears the control fields, the addend, the accumulator, the count, the staged low word and the high shadow on that clock edge. The other bits of that write are ignored.
- R6: A read of the low word captures the current high word into a shadow register. A read of the high word returns the shadow, not the live high word.
- R7: A write to the low word only stages the value and leaves the count unchanged. A write to the high word loads the count with {written high, staged low} on that edge.
- R8: An addend write is used from the next reference cycle onward, and the accumulator contents carry over unchanged.
- R9: After hardware reset every register reads 0 and `timeNow` is 0.
- R10: The count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect on the low word) |
| regAddr | input | 2 | Register select |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid in the cycle regRdEn is high |
| timeNow | output | 64 | Current nanosecond count |

## Verification
The bench builds the block with its default widths: a 32-bit addend and accumulator, a 10-bit period field and a 64-bit count split into two 32-bit words. This makes exact carry counts reachable in a few cycles. With addends near 0x80000000 and 0xFFFFFFFF, a single cycle shows whether the accumulator residue was kept, held or cleared. Count preloads just below 2^32 and 2^64 put the low-word carry and the full wrap within one or two steps. The largest period value, 1023, checks the full width of the period field.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  parameter int BUS_W    = 32;
  parameter int ADD_W    = 32;
  parameter int PER_W    = 10;
  parameter int PER_LSB  = 16;
  parameter int SRC_W    = 2;
  parameter int SRC_LSB  = 0;
  parameter int EN_BIT   = 2;
  parameter int BYP_BIT  = 3;
  parameter int SRST_BIT = 5;
  localparam int COUNT_W = 2 * BUS_W;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_ADDEND = 2'd1,
    ADDR_CNT_LO = 2'd2,
    ADDR_CNT_HI = 2'd3
  } regSelE;

  // strobes and live settings from control to datapath
  typedef struct packed {
    logic               clr;
    logic               load;
    logic [COUNT_W-1:0] loadVal;
    logic               enable;
    logic               bypass;
    logic [PER_W-1:0]   period;
    logic [ADD_W-1:0]   addend;
  } ctlBusT;
endpackage

// File: rtl/tcnt_ctrl.sv
module tcnt_ctrl
  import tcnt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BUS_W-1:0]   regWrData,
  output logic [BUS_W-1:0]   regRdData,
  input  logic [COUNT_W-1:0] timeIn,
  output ctlBusT             ctl
);
  logic              enReg;
  logic              bypReg;
  logic [SRC_W-1:0]  srcReg;
  logic [PER_W-1:0]  perReg;
  logic [ADD_W-1:0]  addendReg;
  logic [BUS_W-1:0]  loStage;
  logic [BUS_W-1:0]  hiShadow;
  logic [BUS_W-1:0]  ctrlWord;

  logic wrCtrl, wrAdd, wrLo, wrHi, rdLo, softClr;

  assign wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
  assign wrAdd   = regWrEn && (regAddr == ADDR_ADDEND);
  assign wrLo    = regWrEn && (regAddr == ADDR_CNT_LO);
  assign wrHi    = regWrEn && (regAddr == ADDR_CNT_HI);
  assign rdLo    = regRdEn && (regAddr == ADDR_CNT_LO);
  assign softClr = wrCtrl && regWrData[SRST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= 1'b0;
      bypReg    <= 1'b0;
      srcReg    <= '0;
      perReg    <= '0;
      addendReg <= '0;
      loStage   <= '0;
      hiShadow  <= '0;
    end else if (softClr) begin
      enReg     <= 1'b0;
      bypReg    <= 1'b0;
      srcReg    <= '0;
      perReg    <= '0;
      addendReg <= '0;
      loStage   <= '0;
      hiShadow  <= '0;
    end else begin
      if (wrCtrl) begin
        enReg  <= regWrData[EN_BIT];
        bypReg <= regWrData[BYP_BIT];
        srcReg <= regWrData[SRC_LSB +: SRC_W];
        perReg <= regWrData[PER_LSB +: PER_W];
      end
      if (wrAdd) addendReg <= regWrData[ADD_W-1:0];
      if (wrLo)  loStage   <= regWrData;
      if (rdLo)  hiShadow  <= timeIn[COUNT_W-1:BUS_W];
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[EN_BIT]              = enReg;
    ctrlWord[BYP_BIT]             = bypReg;
    ctrlWord[SRC_LSB +: SRC_W]    = srcReg;
    ctrlWord[PER_LSB +: PER_W]    = perReg;
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        ADDR_CTRL:   regRdData = ctrlWord;
        ADDR_ADDEND: regRdData = BUS_W'(addendReg);
        ADDR_CNT_LO: regRdData = timeIn[BUS_W-1:0];
        ADDR_CNT_HI: regRdData = hiShadow;
        default:     regRdData = '0;
      endcase
    end
  end

  always_comb begin
    ctl.clr     = softClr;
    ctl.load    = wrHi;
    ctl.loadVal = {regWrData, loStage};
    ctl.enable  = enReg;
    ctl.bypass  = bypReg;
    ctl.period  = perReg;
    ctl.addend  = addendReg;
  end
endmodule

// File: rtl/tcnt_dp.sv
module tcnt_dp
  import tcnt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlBusT             ctl,
  output logic [ADD_W-1:0]   accum,
  output logic [COUNT_W-1:0] count
);
  logic [ADD_W:0]     accSum;
  logic               carry;
  logic               stepNow;
  logic [COUNT_W-1:0] stepVal;

  assign accSum  = {1'b0, accum} + {1'b0, ctl.addend};
  assign carry   = accSum[ADD_W];
  assign stepNow = ctl.bypass || carry;
  assign stepVal = stepNow ? COUNT_W'(ctl.period) : '0;

  // phase accumulator: frozen in bypass and while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          accum <= '0;
    else if (ctl.clr)                   accum <= '0;
    else if (ctl.enable && !ctl.bypass) accum <= accSum[ADD_W-1:0];
  end

  // nanosecond count: load wins over a step on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           count <= '0;
    else if (ctl.clr)    count <= '0;
    else if (ctl.load)   count <= ctl.loadVal;
    else if (ctl.enable) count <= count + stepVal;
  end
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
  import tcnt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BUS_W-1:0]   regWrData,
  output logic [BUS_W-1:0]   regRdData,
  output logic [COUNT_W-1:0] timeNow
);
  ctlBusT             ctlBus;
  logic [ADD_W-1:0]   accum;
  logic [COUNT_W-1:0] count;

  tcnt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .timeIn    (count),
    .ctl       (ctlBus)
  );

  tcnt_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctlBus),
    .accum (accum),
    .count (count)
  );

  assign timeNow = count;
endmodule

// File: rtl/tcnt_checker.sv
module tcnt_checker
  import tcnt_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               clr,
  input logic               load,
  input logic [COUNT_W-1:0] loadVal,
  input logic               enable,
  input logic               bypass,
  input logic [PER_W-1:0]   period,
  input logic [ADD_W-1:0]   accum,
  input logic [COUNT_W-1:0] count,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [BUS_W-1:0]   regRdData
);
  AST_STEP_IS_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !clr && !load) |=>
      (count == $past(count) || count == $past(count) + COUNT_W'($past(period)))); // R1

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !clr && !load) |=> ($stable(count) && $stable(accum))); // R4

  AST_BYPASS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && bypass && !clr && !load) |=>
      (count == $past(count) + COUNT_W'($past(period)) && $stable(accum))); // R3

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0 && accum == '0)); // R5

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (load && !clr) |=> (count == $past(loadVal))); // R7

  AST_SHADOW_READ: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_CNT_LO && !clr) |=>
      (!(regRdEn && regAddr == ADDR_CNT_HI) ||
       regRdData == $past(count[COUNT_W-1:BUS_W]))); // R6
endmodule

bind ns_time_counter tcnt_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clr       (ctlBus.clr),
  .load      (ctlBus.load),
  .loadVal   (ctlBus.loadVal),
  .enable    (ctlBus.enable),
  .bypass    (ctlBus.bypass),
  .period    (ctlBus.period),
  .accum     (accum),
  .count     (count),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regRdData (regRdData)
);

// File: tb/sim_ns_time_counter.sv
`timescale 1ns/1ps
module sim_ns_time_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] timeNow;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  // reference model state
  logic [31:0] mAcc = '0;
  logic [63:0] mCnt = '0;
  logic [31:0] mAdd = '0;
  logic [9:0]  mPer = '0;

  always #4 clk = ~clk;

  ns_time_counter u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .timeNow(timeNow)
  );

  function automatic logic [31:0] mkCtrl(input logic [9:0] per, input bit en,
                                         input bit byp, input logic [1:0] src);
    logic [31:0] w;
    w = '0;
    w[25:16] = per;
    w[2] = en;
    w[3] = byp;
    w[1:0] = src;
    return w;
  endfunction

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (regRdEn && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (regRdData !== e) begin
        failures++;
        $display("FAIL %s: read addr %0d got %h expected %h", t, regAddr, regRdData, e);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    regRdEn = 1'b1; regAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(posedge clk); #1;
    regRdEn = 1'b0;
  endtask

  task automatic checkTime(input logic [63:0] e, input string t);
    checks++;
    if (timeNow !== e) begin
      failures++;
      $display("FAIL %s: timeNow got %h expected %h", t, timeNow, e);
    end
  endtask

  // enable, wait n cycles, disable: n+1 enabled edges
  task automatic runTimer(input bit byp, input int n);
    int m;
    logic [63:0] tmp;
    wr(2'd0, mkCtrl(mPer, 1'b1, byp, 2'd0));
    idle(n);
    wr(2'd0, mkCtrl(mPer, 1'b0, byp, 2'd0));
    m = n + 1;
    if (byp) mCnt = mCnt + 64'(m) * 64'(mPer);
    else begin
      tmp = {32'b0, mAcc} + 64'(m) * {32'b0, mAdd};
      mCnt = mCnt + (tmp >> 32) * 64'(mPer);
      mAcc = tmp[31:0];
    end
  endtask

  task automatic readCount(input string t);
    rd(2'd2, mCnt[31:0], t);
    rd(2'd3, mCnt[63:32], t);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R9 reset state
    checkTime(64'd0, "R9");
    rd(2'd0, 32'd0, "R9");
    rd(2'd1, 32'd0, "R9");
    readCount("R9");

    // R2 control fields read back, bit 5 and spare bits read 0
    mPer = 10'd10;
    wr(2'd0, mkCtrl(mPer, 1'b0, 1'b0, 2'd2) | 32'hC000_4040);
    rd(2'd0, mkCtrl(mPer, 1'b0, 1'b0, 2'd2), "R2");
    mAdd = 32'h9999_99A4;
    wr(2'd1, mAdd);
    rd(2'd1, mAdd, "R2");

    // R1 drift compensated counting: 11 edges -> 6 carries
    runTimer(1'b0, 10);
    readCount("R1");
    checkTime(mCnt, "R1");

    // R4 held while disabled, writes still land
    idle(6);
    readCount("R4");
    mAdd = 32'h8000_0000;
    wr(2'd1, mAdd);
    rd(2'd1, mAdd, "R4");

    // R8 accumulator residue kept across addend change: one edge carries
    runTimer(1'b0, 0);
    readCount("R8");

    // R7 low write is only staged
    wr(2'd2, 32'hFFFF_FFFE);
    rd(2'd2, mCnt[31:0], "R7");
    wr(2'd3, 32'h0000_0001);
    mCnt = 64'h0000_0001_FFFF_FFFE;
    readCount("R7");

    // R6 high read returns shadow captured by the low read
    rd(2'd2, mCnt[31:0], "R6");
    wr(2'd2, 32'h0000_0010);
    wr(2'd3, 32'h0000_0005);
    rd(2'd3, 32'h0000_0001, "R6");
    mCnt = 64'h0000_0005_0000_0010;
    readCount("R6");

    // R3 bypass: step every edge, accumulator frozen
    mPer = 10'd7;
    runTimer(1'b1, 4);
    readCount("R3");
    mAdd = 32'h7000_0000;
    wr(2'd1, mAdd);
    runTimer(1'b0, 0);
    readCount("R3");
    runTimer(1'b0, 1);
    readCount("R3");

    // R10 wrap modulo 2^64
    wr(2'd2, 32'hFFFF_FFFE);
    wr(2'd3, 32'hFFFF_FFFF);
    mCnt = 64'hFFFF_FFFF_FFFF_FFFE;
    mPer = 10'd3;
    runTimer(1'b1, 0);
    readCount("R10");
    checkTime(64'd1, "R10");

    // R5 soft reset clears everything, other bits ignored
    rd(2'd2, mCnt[31:0], "R5");
    wr(2'd0, mkCtrl(10'h3FF, 1'b1, 1'b1, 2'd3) | 32'h20);
    mCnt = '0; mAcc = '0; mAdd = '0; mPer = '0;
    rd(2'd0, 32'd0, "R5");
    rd(2'd1, 32'd0, "R5");
    rd(2'd3, 32'd0, "R5");
    readCount("R5");
    mAdd = 32'hFFFF_FFFF;
    wr(2'd1, mAdd);
    mPer = 10'd4;
    runTimer(1'b0, 0);
    readCount("R5");

    // R2 full-width period in bypass
    mPer = 10'h3FF;
    runTimer(1'b1, 1);
    readCount("R2");
    checkTime(mCnt, "R2");

    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule